// File: doc/BRIEF.md
# SMBus Register Command Engine

This block is a single-master SMBus/I2C controller that sits beside a memory controller and talks to the small devices on a memory module: configuration EEPROMs and temperature sensors. Software uses three 32-bit registers. The control register holds the upper four bits of the target address, which name the device class, together with the mode bits. One write to the command register with its launch bit set starts a single byte or word, read or write transaction. The status register shows whether the engine is busy, the completion flags, the bus-error flag and the returned data.

The target address is split. Its upper four bits come from the control register and its lower three bits come from the command word. The two completion flags are independent. Each one is cleared only when an operation of its own kind starts. Read data comes back in the status register. In a word transfer the first byte on the wire maps to bits [15:8].

A background poller can be switched on. It periodically reads a word from a sensor register without touching any software-visible flag. The wire side has two open-drain outputs that pull SCL and SDA low, plus the sensed SDA level. The register port has no stall: every write takes effect on the clock edge where it is presented. A launch that is not accepted is simply dropped. There is no data stream and so no valid/ready back-pressure.

Top module: `smbus_cmd_engine`

## Requirements
- R1: After reset, control and status read as zero, and SCL and SDA are both released. While the engine is not busy, both lines stay released.
- R2: The command register is selected with reg_sel = 1 and reads back the last fields written while idle. Bit 31 always reads as zero.
- R3: A byte write sends START, the address byte {target[6:0],0}, the command byte (command bits [23:16]), data bits [7:0], then STOP. Bits [15:8] are ignored. On completion, write-done (status bit 26) is set.
- R4: A word write (command bit 29 set) sends data bits [15:8] first and then bits [7:0].
- R5: A byte read sends START, {target,0}, the command byte, a repeated START and {target,1}. It then takes one byte, answers it with NACK and sends STOP. The byte lands in status bits [7:0], with [15:8] zero, and read-valid (status bit 25) is set.
- R6: A word read takes two bytes, with ACK after the first and NACK after the second. The first byte lands in status bits [15:8] and the second in bits [7:0].
- R7: Read-valid is cleared only when a host read starts. Write-done is cleared only when a host write starts. A write leaves read-valid untouched, and a read leaves write-done untouched.
- R8: If any address or write byte is not acknowledged, bus-error (status bit 27) is set and the transaction goes straight to STOP. Bus-error is cleared when the next host transaction starts.
- R9: A completed write whose device class (control bits [31:28]) is 0x6 always reports bus-error, even when every byte was acknowledged. Reads of that class do not.
- R10: A launch written while busy is ignored.
- R11: A launch is ignored while clock-enable (control bit 27) is clear. A write launch is ignored while write-lock (control bit 26) is set, and a read launch is still accepted in that case.
- R12: With poll-enable (control bit 9) set and the engine idle, the engine issues a word read of register POLL_REG at address {class, POLL_LOW} by itself. This poll leaves the status flags and data untouched. Clearing poll-enable lets an in-flight poll finish, and then no further polls start.
- R13: Busy (status bit 28) reads as one in the cycle after an accepted launch and stays one until STOP has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 command, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| scl_oe | output | 1 | Pulls SCL low when 1 |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| sda_i | input | 1 | Sensed SDA level |

## Verification
The main function is swept over all four combinations of byte or word and read or write, each with several data patterns (all zeros, all ones, alternating and mixed). The byte log seen on the wire separates byte order and the ignored upper byte in writes. The read patterns separate the byte placement in status bits [15:8] and [7:0]. Further sequences cover the following:
- a read-then-write-then-read order, which tells the two completion flags apart;
- a target that refuses its address, against the page-select class that acknowledges everything;
- launches under the clock-enable and write-lock conditions, and a launch issued while busy, which show that dropped commands never reach the wire;
- polling on and off, which shows that a background read leaves status untouched.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [1:0] {BOP_START, BOP_STOP, BOP_BIT} bop_e;

  typedef enum logic [3:0] {
    T_IDLE, T_START, T_ADDRW, T_CMD, T_WHI, T_WLO,
    T_RSTART, T_ADDRR, T_RHI, T_RLO, T_STOP
  } tstate_e;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_CMD  = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;

  localparam int CT_OVR  = 27;
  localparam int CT_WDIS = 26;
  localparam int CT_POLL = 9;

  localparam int CM_TRIG = 31;
  localparam int CM_WORD = 29;
  localparam int CM_WR   = 27;

  localparam int ST_BUSY   = 28;
  localparam int ST_ERR    = 27;
  localparam int ST_WDONE  = 26;
  localparam int ST_RVALID = 25;

  localparam logic [3:0] PAGE_CLASS = 4'h6;
endpackage

// File: rtl/smb_bit_phy.sv
// One bus symbol (START, STOP or a data/ack bit) per request, in four quarter periods.
module smb_bit_phy
  import smb_pkg::*;
#(
  parameter int QTR = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  bop_e op,
  input  logic bit_in,
  input  logic sda_i,
  output logic done,
  output logic bit_out,
  output logic scl_low,
  output logic sda_low
);
  localparam int CW = (QTR > 1) ? $clog2(QTR) : 1;

  logic          active;
  logic [1:0]    q;
  logic [CW-1:0] cnt;
  bop_e          op_r;
  logic          bit_r;

  logic [1:0] nq;
  logic       load;
  bop_e       cur_op;
  logic       cur_bit;
  logic       qend;

  assign qend    = active && (cnt == CW'(QTR - 1));
  assign load    = (!active && go) || (qend && q != 2'd3);
  assign nq      = active ? q + 2'd1 : 2'd0;
  assign cur_op  = active ? op_r : op;
  assign cur_bit = active ? bit_r : bit_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      q       <= 2'd0;
      cnt     <= '0;
      op_r    <= BOP_BIT;
      bit_r   <= 1'b1;
      done    <= 1'b0;
      bit_out <= 1'b1;
      scl_low <= 1'b0;
      sda_low <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active && go) begin
        active <= 1'b1;
        op_r   <= op;
        bit_r  <= bit_in;
        cnt    <= '0;
        q      <= 2'd0;
      end else if (active) begin
        if (qend) begin
          cnt <= '0;
          if (q == 2'd3) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            q <= nq;
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
      if (load) begin
        unique case (cur_op)
          BOP_START: case (nq)
            2'd0: sda_low <= 1'b0;
            2'd1: scl_low <= 1'b0;
            2'd2: sda_low <= 1'b1;
            default: scl_low <= 1'b1;
          endcase
          BOP_STOP: case (nq)
            2'd0: sda_low <= 1'b1;
            2'd1: scl_low <= 1'b0;
            2'd2: ;
            default: sda_low <= 1'b0;
          endcase
          default: case (nq)
            2'd0: begin scl_low <= 1'b1; sda_low <= ~cur_bit; end
            2'd1: scl_low <= 1'b0;
            2'd2: bit_out <= sda_i;
            default: scl_low <= 1'b1;
          endcase
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_txn_seq.sv
// Byte-level transaction sequencer driving the bit phy one symbol at a time.
module smb_txn_seq
  import smb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        is_wr,
  input  logic        is_word,
  input  logic [6:0]  addr,
  input  logic [7:0]  cmd,
  input  logic [15:0] wdata,
  output logic        busy,
  output logic        fin,
  output logic        err,
  output logic [15:0] rdata,
  output logic        bop_go,
  output bop_e        bop_op,
  output logic        bop_bit,
  input  logic        bop_done,
  input  logic        bop_rx
);
  tstate_e    st;
  logic [7:0] sh;
  logic [3:0] bitn;
  logic       rx_st;

  assign rx_st = (st == T_RHI) || (st == T_RLO);
  assign busy  = (st != T_IDLE);

  always_comb begin
    if (st == T_START || st == T_RSTART) bop_op = BOP_START;
    else if (st == T_STOP)               bop_op = BOP_STOP;
    else                                 bop_op = BOP_BIT;
    if (bitn != 4'd8) bop_bit = rx_st ? 1'b1 : sh[7];
    else              bop_bit = rx_st ? (st == T_RLO) : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= T_IDLE;
      sh     <= '0;
      bitn   <= '0;
      bop_go <= 1'b0;
      fin    <= 1'b0;
      err    <= 1'b0;
      rdata  <= '0;
    end else begin
      bop_go <= 1'b0;
      fin    <= 1'b0;
      if (st == T_IDLE) begin
        if (start) begin
          st     <= T_START;
          bop_go <= 1'b1;
          err    <= 1'b0;
          rdata  <= '0;
          bitn   <= '0;
        end
      end else if (bop_done) begin
        bop_go <= 1'b1;
        bitn   <= '0;
        case (st)
          T_START:  begin st <= T_ADDRW; sh <= {addr, 1'b0}; end
          T_RSTART: begin st <= T_ADDRR; sh <= {addr, 1'b1}; end
          T_STOP:   begin st <= T_IDLE; bop_go <= 1'b0; fin <= 1'b1; end
          default: begin
            if (bitn != 4'd8) begin
              bitn <= bitn + 4'd1;
              sh   <= {sh[6:0], rx_st ? bop_rx : 1'b0};
            end else if (rx_st) begin
              if (st == T_RHI) begin rdata[15:8] <= sh; st <= T_RLO; end
              else             begin rdata[7:0]  <= sh; st <= T_STOP; end
            end else if (bop_rx) begin
              err <= 1'b1;
              st  <= T_STOP;
            end else begin
              case (st)
                T_ADDRW: begin st <= T_CMD; sh <= cmd; end
                T_CMD: begin
                  if (!is_wr)       st <= T_RSTART;
                  else if (is_word) begin st <= T_WHI; sh <= wdata[15:8]; end
                  else              begin st <= T_WLO; sh <= wdata[7:0]; end
                end
                T_WHI:   begin st <= T_WLO; sh <= wdata[7:0]; end
                T_ADDRR: st <= is_word ? T_RHI : T_RLO;
                default: st <= T_STOP;
              endcase
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/smbus_cmd_engine.sv
module smbus_cmd_engine
  import smb_pkg::*;
#(
  parameter int         CLK_HZ   = 100_000_000,
  parameter int         SCL_HZ   = 100_000,
  parameter int         POLL_GAP = 1_000_000,
  parameter logic [2:0] POLL_LOW = 3'b000,
  parameter logic [7:0] POLL_REG = 8'h05
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        scl_oe,
  output logic        sda_oe,
  input  logic        sda_i
);
  localparam int QRAW = CLK_HZ / (4 * SCL_HZ);
  localparam int QTR  = (QRAW > 0) ? QRAW : 1;
  localparam int PW   = $clog2(POLL_GAP + 1);

  logic [31:0] ctrl_q;
  logic [30:0] cmd_q;
  logic        st_err, st_wdone, st_rvalid;
  logic [15:0] st_data;
  logic [PW-1:0] poll_cnt;

  logic        owner_host, t_wr, t_word;
  logic [6:0]  t_addr;
  logic [7:0]  t_cmd;
  logic [15:0] t_wdata;

  logic        seq_busy, seq_fin, seq_err;
  logic [15:0] seq_rdata;
  logic        bop_go, bop_bit, bop_done, bop_rx;
  bop_e        bop_op;

  logic trig, host_ok, poll_go, seq_start;

  assign trig    = reg_wr_en && (reg_sel == SEL_CMD) && reg_wdata[CM_TRIG];
  assign host_ok = trig && !seq_busy && ctrl_q[CT_OVR] &&
                   !(reg_wdata[CM_WR] && ctrl_q[CT_WDIS]);
  assign poll_go = ctrl_q[CT_POLL] && ctrl_q[CT_OVR] && !seq_busy && !host_ok &&
                   (poll_cnt == PW'(POLL_GAP - 1));
  assign seq_start = host_ok || poll_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; cmd_q <= '0;
      st_err <= 1'b0; st_wdone <= 1'b0; st_rvalid <= 1'b0; st_data <= '0;
      poll_cnt <= '0;
      owner_host <= 1'b0; t_wr <= 1'b0; t_word <= 1'b0;
      t_addr <= '0; t_cmd <= '0; t_wdata <= '0;
    end else begin
      if (reg_wr_en && reg_sel == SEL_CTRL) ctrl_q <= reg_wdata;
      if (reg_wr_en && reg_sel == SEL_CMD && !seq_busy) cmd_q <= reg_wdata[30:0];

      if (!ctrl_q[CT_POLL] || !ctrl_q[CT_OVR] || seq_busy || seq_start) poll_cnt <= '0;
      else poll_cnt <= poll_cnt + PW'(1);

      if (seq_fin && owner_host) begin
        st_err <= seq_err || (t_wr && t_addr[6:3] == PAGE_CLASS);
        if (t_wr) st_wdone <= 1'b1;
        else begin st_rvalid <= 1'b1; st_data <= seq_rdata; end
      end

      if (seq_start) begin
        owner_host <= host_ok;
        if (host_ok) begin
          t_wr    <= reg_wdata[CM_WR];
          t_word  <= reg_wdata[CM_WORD];
          t_addr  <= {ctrl_q[31:28], reg_wdata[26:24]};
          t_cmd   <= reg_wdata[23:16];
          t_wdata <= reg_wdata[15:0];
          st_err  <= 1'b0;
          if (reg_wdata[CM_WR]) st_wdone <= 1'b0;
          else                  st_rvalid <= 1'b0;
        end else begin
          t_wr    <= 1'b0;
          t_word  <= 1'b1;
          t_addr  <= {ctrl_q[31:28], POLL_LOW};
          t_cmd   <= POLL_REG;
          t_wdata <= '0;
        end
      end
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_CTRL: reg_rdata = ctrl_q;
      SEL_CMD:  reg_rdata = {1'b0, cmd_q};
      SEL_STAT: reg_rdata = {3'b000, seq_busy, st_err, st_wdone, st_rvalid,
                             9'd0, st_data};
      default:  reg_rdata = '0;
    endcase
  end

  smb_txn_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(seq_start), .is_wr(t_wr), .is_word(t_word),
    .addr(t_addr), .cmd(t_cmd), .wdata(t_wdata), .busy(seq_busy), .fin(seq_fin),
    .err(seq_err), .rdata(seq_rdata), .bop_go(bop_go), .bop_op(bop_op),
    .bop_bit(bop_bit), .bop_done(bop_done), .bop_rx(bop_rx)
  );

  smb_bit_phy #(.QTR(QTR)) u_phy (
    .clk(clk), .rst_n(rst_n), .go(bop_go), .op(bop_op), .bit_in(bop_bit),
    .sda_i(sda_i), .done(bop_done), .bit_out(bop_rx),
    .scl_low(scl_oe), .sda_low(sda_oe)
  );
endmodule

// File: rtl/smb_engine_chk.sv
module smb_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  reg_sel,
  input logic [31:0] reg_rdata,
  input logic [31:0] reg_wdata,
  input logic        scl_oe,
  input logic        sda_oe,
  input logic        seq_busy,
  input logic        seq_fin,
  input logic        host_ok,
  input logic        owner_host,
  input logic        t_wr,
  input logic [6:0]  t_addr,
  input logic        st_err,
  input logic        st_wdone,
  input logic        st_rvalid
);
  a_r2_trig_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd1) |-> !reg_rdata[31]);

  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_busy |-> (!scl_oe && !sda_oe));

  a_r7_rvalid_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_rvalid) |-> $past(host_ok && !reg_wdata[27]));

  a_r7_wdone_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_wdone) |-> $past(host_ok && reg_wdata[27]));

  a_r9_page_error: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_fin && owner_host && t_wr && t_addr[6:3] == 4'h6 && !host_ok) |=> st_err);

  a_r13_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
    host_ok |=> seq_busy);

  a_r13_fin_idle: assert property (@(posedge clk) disable iff (!rst_n)
    seq_fin |-> !seq_busy);
endmodule

bind smbus_cmd_engine smb_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_rdata(reg_rdata),
  .reg_wdata(reg_wdata), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .seq_busy(seq_busy), .seq_fin(seq_fin), .host_ok(host_ok),
  .owner_host(owner_host), .t_wr(t_wr), .t_addr(t_addr),
  .st_err(st_err), .st_wdone(st_wdone), .st_rvalid(st_rvalid)
);

// File: tb/smbus_cmd_engine_tb.sv
`timescale 1ns/1ps
module smbus_cmd_engine_tb;
  localparam int         GAP  = 3000;
  localparam logic [2:0] PLOW = 3'b010;
  localparam logic [7:0] PREG = 8'h05;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic scl_oe, sda_oe;
  logic tgt_low = 1'b0;
  wire scl = ~scl_oe;
  wire sda = ~(sda_oe | tgt_low);

  always #2 clk = ~clk;

  smbus_cmd_engine #(.CLK_HZ(250_000_000), .SCL_HZ(12_500_000), .POLL_GAP(GAP),
                     .POLL_LOW(PLOW), .POLL_REG(PREG)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .sda_i(sda)
  );

  // behavioural target
  logic [6:0] tgt_addr = 7'h1A;
  logic       nack_all = 1'b0;
  logic [7:0] rd_b0 = 8'h00, rd_b1 = 8'h00;
  logic [7:0] logb [0:255];
  int nlog = 0, nstop = 0;
  logic pscl = 1'b1, psda = 1'b1;
  logic in_txn = 1'b0, first = 1'b0, rd_mode = 1'b0, reading = 1'b0, ninth = 1'b0, m_ack = 1'b0;
  int bcnt = 0, ridx = 0;
  logic [7:0] shreg = '0, txb = '0;

  always @(scl, sda) begin
    if (scl === 1'b1 && pscl === 1'b1 && sda !== psda) begin
      if (sda === 1'b0) begin
        in_txn = 1'b1; first = 1'b1; rd_mode = 1'b0; reading = 1'b0;
        ninth = 1'b0; bcnt = 0; tgt_low = 1'b0;
      end else if (sda === 1'b1) begin
        nstop++; in_txn = 1'b0; tgt_low = 1'b0;
      end
    end else if (scl === 1'b1 && pscl === 1'b0) begin
      if (in_txn) begin
        if (bcnt < 8) begin shreg = {shreg[6:0], sda}; bcnt++; end
        else begin m_ack = (sda === 1'b0); ninth = 1'b1; end
      end
    end else if (scl === 1'b0 && pscl === 1'b1) begin
      if (in_txn) begin
        if (ninth) begin
          ninth = 1'b0; bcnt = 0; tgt_low = 1'b0;
          if (reading) begin
            if (m_ack) begin txb = (ridx == 0) ? rd_b0 : rd_b1; ridx++; tgt_low = ~txb[7]; end
            else begin reading = 1'b0; in_txn = 1'b0; end
          end else if (rd_mode) begin
            reading = 1'b1; ridx = 1; txb = rd_b0; tgt_low = ~txb[7];
          end
        end else if (bcnt == 8) begin
          if (reading) tgt_low = 1'b0;
          else begin
            logb[nlog[7:0]] = shreg; nlog++;
            if (first) begin
              first = 1'b0; rd_mode = shreg[0];
              tgt_low = (shreg[7:1] == tgt_addr) && !nack_all;
            end else tgt_low = !nack_all;
            if (!tgt_low) begin in_txn = 1'b0; rd_mode = 1'b0; end
          end
        end else if (reading) tgt_low = ~txb[7 - bcnt];
      end
    end
    pscl = scl; psda = sda;
  end

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); reg_sel = sel; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk); reg_wr_en = 1'b0; reg_sel = 2'd2;
  endtask

  task automatic reg_read(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk); reg_sel = sel; #1; d = reg_rdata;
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] s;
    bit idle = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      reg_read(2'd2, s);
      if (!s[28]) begin idle = 1'b1; break; end
    end
    if (!idle) chk({tag, " hung busy"}, 32'd1, 32'd0);
  endtask

  function automatic logic [31:0] mk_cmd(input logic word, input logic wr,
                                         input logic [2:0] low, input logic [7:0] c,
                                         input logic [15:0] d);
    return {1'b1, 1'b0, word, 1'b0, wr, low, c, d};
  endfunction

  task automatic launch(input string tag, input logic word, input logic wr,
                        input logic [7:0] c, input logic [15:0] d);
    logic [31:0] s;
    reg_write(2'd1, mk_cmd(word, wr, tgt_addr[2:0], c, d));
    reg_read(2'd2, s);
    chk({tag, " R13 busy after launch"}, {31'd0, s[28]}, 32'd1);
    wait_idle(tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] s, c;
    logic [15:0] pats [4];
    int base, ns;
    pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'hA55A; pats[3] = 16'h1234;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_read(2'd2, s); chk("R1 status after reset", s, 32'd0);
    reg_read(2'd0, s); chk("R1 control after reset", s, 32'd0);
    chk("R1 lines released", {30'd0, scl, sda}, 32'd3);

    // R11 clock-enable clear: launch ignored; R2 readback
    base = nlog;
    reg_write(2'd1, mk_cmd(1'b1, 1'b1, 3'b101, 8'hC3, 16'h5A0F));
    reg_read(2'd2, s); chk("R11 no busy without clock enable", {31'd0, s[28]}, 32'd0);
    repeat (50) @(negedge clk);
    chk("R11 nothing on wire", nlog - base, 32'd0);
    reg_read(2'd1, c);
    chk("R2 launch bit reads zero", {31'd0, c[31]}, 32'd0);
    chk("R2 fields read back", c, 32'h2DC3_5A0F);

    reg_write(2'd0, 32'h3800_0000);

    // R3..R6 sweep
    for (int op = 0; op < 4; op++) begin
      for (int p = 0; p < 4; p++) begin
        logic word, wr;
        logic [7:0] cb;
        word = op[0]; wr = op[1]; cb = 8'h10 + 8'(op * 4 + p);
        rd_b0 = pats[p][15:8]; rd_b1 = pats[p][7:0];
        base = nlog; ns = nstop;
        launch("sweep", word, wr, cb, pats[p]);
        chk("R3 STOP seen", nstop - ns, 32'd1);
        chk("R3 address byte", {24'd0, logb[base[7:0]]}, {24'd0, tgt_addr, 1'b0});
        chk("R3 command byte", {24'd0, logb[8'(base + 1)]}, {24'd0, cb});
        reg_read(2'd2, s);
        if (wr) begin
          chk(word ? "R4 byte count" : "R3 byte count", nlog - base, word ? 32'd4 : 32'd3);
          if (word) begin
            chk("R4 first data byte", {24'd0, logb[8'(base + 2)]}, {24'd0, pats[p][15:8]});
            chk("R4 second data byte", {24'd0, logb[8'(base + 3)]}, {24'd0, pats[p][7:0]});
          end else
            chk("R3 low byte only", {24'd0, logb[8'(base + 2)]}, {24'd0, pats[p][7:0]});
          chk("R3 write-done", {31'd0, s[26]}, 32'd1);
        end else begin
          chk("R5 read address byte", {24'd0, logb[8'(base + 2)]}, {24'd0, tgt_addr, 1'b1});
          chk(word ? "R6 read data" : "R5 read data", {16'd0, s[15:0]},
              word ? {16'd0, pats[p]} : {24'd0, pats[p][15:8]});
          chk("R5 read-valid", {31'd0, s[25]}, 32'd1);
        end
        chk("R8 no error on ack", {31'd0, s[27]}, 32'd0);
      end
    end

    // R7 flag independence
    launch("R7 read", 1'b0, 1'b0, 8'h20, 16'h0);
    launch("R7 write", 1'b0, 1'b1, 8'h21, 16'h0033);
    reg_read(2'd2, s);
    chk("R7 write keeps read-valid", {30'd0, s[26:25]}, 32'd3);
    reg_write(2'd1, mk_cmd(1'b0, 1'b0, tgt_addr[2:0], 8'h22, 16'h0));
    reg_read(2'd2, s);
    chk("R7 read start clears only read-valid", {30'd0, s[26:25]}, 32'd2);
    wait_idle("R7");

    // R8 NACK
    nack_all = 1'b1; base = nlog; ns = nstop;
    launch("R8 nack", 1'b1, 1'b1, 8'h30, 16'hBEEF);
    reg_read(2'd2, s);
    chk("R8 error set", {31'd0, s[27]}, 32'd1);
    chk("R8 stops after address", nlog - base, 32'd1);
    chk("R8 STOP issued", nstop - ns, 32'd1);
    nack_all = 1'b0;
    reg_write(2'd1, mk_cmd(1'b0, 1'b1, tgt_addr[2:0], 8'h31, 16'h0001));
    reg_read(2'd2, s);
    chk("R8 error cleared at start", {31'd0, s[27]}, 32'd0);
    wait_idle("R8");

    // R9 page-select class
    tgt_addr = 7'h32; reg_write(2'd0, 32'h6800_0000);
    base = nlog;
    launch("R9 write", 1'b0, 1'b1, 8'h00, 16'h0000);
    reg_read(2'd2, s);
    chk("R9 all bytes acked", nlog - base, 32'd3);
    chk("R9 error forced on write", {31'd0, s[27]}, 32'd1);
    launch("R9 read", 1'b0, 1'b0, 8'h00, 16'h0000);
    reg_read(2'd2, s);
    chk("R9 no error on read", {31'd0, s[27]}, 32'd0);
    tgt_addr = 7'h1A; reg_write(2'd0, 32'h3800_0000);

    // R10 launch while busy
    base = nlog;
    reg_write(2'd1, mk_cmd(1'b0, 1'b1, tgt_addr[2:0], 8'h40, 16'h0011));
    reg_write(2'd1, mk_cmd(1'b1, 1'b1, tgt_addr[2:0], 8'h77, 16'h9999));
    wait_idle("R10");
    repeat (200) @(negedge clk);
    chk("R10 only one transaction", nlog - base, 32'd3);
    chk("R10 first command kept", {24'd0, logb[8'(base + 1)]}, 32'h40);
    chk("R10 first data kept", {24'd0, logb[8'(base + 2)]}, 32'h11);

    // R11 write-lock
    reg_write(2'd0, 32'h3C00_0000);
    base = nlog;
    reg_write(2'd1, mk_cmd(1'b0, 1'b1, tgt_addr[2:0], 8'h50, 16'h0055));
    reg_read(2'd2, s); chk("R11 locked write not busy", {31'd0, s[28]}, 32'd0);
    repeat (50) @(negedge clk);
    chk("R11 locked write off wire", nlog - base, 32'd0);
    rd_b0 = 8'h6C;
    launch("R11 read under lock", 1'b0, 1'b0, 8'h51, 16'h0);
    reg_read(2'd2, s);
    chk("R11 read accepted under lock", {16'd0, s[15:0]}, 32'h006C);

    // R12 polling
    reg_read(2'd2, c);
    base = nlog;
    reg_write(2'd0, 32'h3800_0200);
    begin
      bit seen = 1'b0;
      for (int i = 0; i < GAP + 500; i++) begin
        reg_read(2'd2, s);
        if (s[28]) begin seen = 1'b1; break; end
      end
      chk("R12 poll made engine busy", {31'd0, seen}, 32'd1);
    end
    reg_write(2'd0, 32'h3800_0000);
    wait_idle("R12");
    chk("R12 poll bytes", nlog - base, 32'd3);
    chk("R12 poll address", {24'd0, logb[base[7:0]]}, {24'd0, 4'h3, PLOW, 1'b0});
    chk("R12 poll register", {24'd0, logb[8'(base + 1)]}, {24'd0, PREG});
    reg_read(2'd2, s);
    chk("R12 status untouched by poll", s, c);
    base = nlog;
    repeat (2 * GAP) @(negedge clk);
    chk("R12 no poll after disable", nlog - base, 32'd0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule